// File: doc/BRIEF.md
# Bounded first-match mask scanner

The block holds a bank of stored compare masks, one per step, and on request searches it for the first mask that equals a presented input pattern exactly. The search starts at step 0. It moves up one step per clock and stops at the first equal mask, or after the step held in a programmable last-step register. The lowest matching step therefore always wins.

On a hit the block returns the step number. On a miss it returns the last step plus one, so the step output is one bit wider than a step index. A last-step value beyond the top of the bank stops the request before any scan. It is reported as a fault with a fixed code.

Masks are loaded one row at a time through a write strobe. The last-step register has its own load strobe. A request is taken only when the enable input is high and no scan is running. The pattern is captured when the request is taken. A single-cycle done pulse marks the moment the result outputs become valid. Those outputs then hold until the next result.

Top module: `pattern_scan_cmp`

## Requirements
- R1: After reset all mask rows read as 0, the last-step register is 0, and done_o, hit_o, step_o, eno_o and err_o are all 0. So a request with pattern 16'h0000 hits step 0.
- R2: A step matches only when every pattern bit i equals mask bit i. A mask that differs from the pattern in a single bit does not match.
- R3: Steps are examined in increasing order, one per clock. Let E0 be the clock edge at which the request is sampled. The result for step s is presented with done_o during the cycle that follows edge E0+s+1. When several steps match, the lowest-numbered one is reported.
- R4: On a match, hit_o=1 and step_o equals the matching step number.
- R5: When no step from 0 up to and including the last step matches, hit_o=0 and step_o equals last+1. done_o rises after edge E0+last+1.
- R6: A last-step value above N_STEPS-1 (15 by default) starts no scan. done_o is high in the cycle right after E0, with eno_o=0, err_o=16'h000E, hit_o=0 and step_o=0.
- R7: Every completed scan, whether hit or miss, reports eno_o=1 and err_o=16'h0000.
- R8: A request with en_i=0 is ignored: no done_o follows and the outputs keep their values.
- R9: A request that arrives while a scan is running is ignored. It neither restarts the scan nor produces a second done_o.
- R10: done_o is high for exactly one cycle per result. hit_o, step_o, eno_o and err_o change only together with done_o.
- R11: wr_en_i writes wr_mask_i into mask row wr_step_i, where bit i of the word is mask bit i. last_we_i loads last_i into the last-step register.
- R12: The pattern is captured when the request is taken. Later changes on pat_i do not affect that scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Mask row write strobe |
| wr_step_i | input | 4 | Mask row to write |
| wr_mask_i | input | 16 | Mask word to write |
| last_we_i | input | 1 | Last-step register load strobe |
| last_i | input | 8 | Last-step value to load |
| req_i | input | 1 | Execute request |
| en_i | input | 1 | Enable; a request counts only while high |
| pat_i | input | 16 | Input pattern to search for |
| done_o | output | 1 | One-cycle result-valid pulse |
| hit_o | output | 1 | 1 when a matching step was found |
| step_o | output | 5 | Matching step, or last+1 on a miss |
| eno_o | output | 1 | 1 on error-free execution |
| err_o | output | 16 | 16'h0000 on success, 16'h000E on out-of-range last step |

## Verification
The bench builds the block with its defaults: a 16-bit pattern, 16 steps and an 8-bit last-step register. With these values a full-length scan, a match at step 15 and the miss value 16 are all reachable, and 16 is the widest value step_o must carry. Last-step values from 16 up to 255 exercise the abort path. Random masks are drawn from a small pool so that duplicate rows occur and lowest-index priority is tested. Measuring the done latency on every request checks the one-step-per-clock timing.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int ERR_W = 16;
  localparam logic [ERR_W-1:0] ERR_NONE  = 16'h0000;
  localparam logic [ERR_W-1:0] ERR_RANGE = 16'h000E;

  typedef enum logic {
    ST_IDLE,
    ST_SCAN
  } scan_state_e;
endpackage

// File: rtl/mask_bank.sv
module mask_bank #(
  parameter int PAT_W   = 16,
  parameter int N_STEPS = 16,
  localparam int IDX_W  = $clog2(N_STEPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [PAT_W-1:0] wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [PAT_W-1:0] rdata_o
);
  logic [PAT_W-1:0] row_q [N_STEPS];

  for (genvar g = 0; g < N_STEPS; g++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                row_q[g] <= '0;
      else if (we_i && waddr_i == IDX_W'(g))      row_q[g] <= wdata_i;
    end
  end

  assign rdata_o = row_q[raddr_i];
endmodule

// File: rtl/step_match.sv
module step_match #(
  parameter int PAT_W = 16
) (
  input  logic [PAT_W-1:0] mask_i,
  input  logic [PAT_W-1:0] pat_i,
  output logic             eq_o
);
  assign eq_o = ~|(mask_i ^ pat_i);
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int PAT_W   = 16,
  parameter int N_STEPS = 16,
  parameter int LAST_W  = 8,
  localparam int IDX_W  = $clog2(N_STEPS),
  localparam int STEP_W = $clog2(N_STEPS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LAST_W-1:0] last_i,
  input  logic [PAT_W-1:0]  pat_i,
  input  logic              match_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [PAT_W-1:0]  pat_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              hit_o,
  output logic [STEP_W-1:0] step_o,
  output logic              eno_o,
  output logic [ERR_W-1:0]  err_o
);
  localparam logic [LAST_W-1:0] LAST_MAX = LAST_W'(N_STEPS - 1);

  scan_state_e       state_q;
  logic [IDX_W-1:0]  idx_q, lim_q;
  logic [PAT_W-1:0]  pat_q;
  logic              done_q, hit_q, eno_q;
  logic [STEP_W-1:0] step_q;
  logic [ERR_W-1:0]  err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      lim_q   <= '0;
      pat_q   <= '0;
      done_q  <= 1'b0;
      hit_q   <= 1'b0;
      step_q  <= '0;
      eno_q   <= 1'b0;
      err_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (last_i > LAST_MAX) begin
              // abort without scanning
              done_q <= 1'b1;
              hit_q  <= 1'b0;
              step_q <= '0;
              eno_q  <= 1'b0;
              err_q  <= ERR_RANGE;
            end else begin
              state_q <= ST_SCAN;
              idx_q   <= '0;
              lim_q   <= last_i[IDX_W-1:0];
              pat_q   <= pat_i;
            end
          end
        end
        ST_SCAN: begin
          if (match_i) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            hit_q   <= 1'b1;
            step_q  <= STEP_W'(idx_q);
            eno_q   <= 1'b1;
            err_q   <= ERR_NONE;
          end else if (idx_q == lim_q) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            hit_q   <= 1'b0;
            step_q  <= STEP_W'(lim_q) + STEP_W'(1);
            eno_q   <= 1'b1;
            err_q   <= ERR_NONE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idx_o  = idx_q;
  assign pat_o  = pat_q;
  assign busy_o = (state_q == ST_SCAN);
  assign done_o = done_q;
  assign hit_o  = hit_q;
  assign step_o = step_q;
  assign eno_o  = eno_q;
  assign err_o  = err_q;
endmodule

// File: rtl/pattern_scan_cmp.sv
module pattern_scan_cmp
  import scan_pkg::*;
#(
  parameter int PAT_W   = 16,
  parameter int N_STEPS = 16,
  parameter int LAST_W  = 8,
  localparam int IDX_W  = $clog2(N_STEPS),
  localparam int STEP_W = $clog2(N_STEPS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_step_i,
  input  logic [PAT_W-1:0]  wr_mask_i,
  input  logic              last_we_i,
  input  logic [LAST_W-1:0] last_i,
  input  logic              req_i,
  input  logic              en_i,
  input  logic [PAT_W-1:0]  pat_i,
  output logic              done_o,
  output logic              hit_o,
  output logic [STEP_W-1:0] step_o,
  output logic              eno_o,
  output logic [ERR_W-1:0]  err_o
);
  logic [LAST_W-1:0] last_q;
  logic [IDX_W-1:0]  rd_idx;
  logic [PAT_W-1:0]  rd_mask, cur_pat;
  logic              match, busy, start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        last_q <= '0;
    else if (last_we_i) last_q <= last_i;
  end

  assign start = req_i & en_i;

  mask_bank #(.PAT_W(PAT_W), .N_STEPS(N_STEPS)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i),
    .waddr_i (wr_step_i),
    .wdata_i (wr_mask_i),
    .raddr_i (rd_idx),
    .rdata_o (rd_mask)
  );

  step_match #(.PAT_W(PAT_W)) u_match (
    .mask_i (rd_mask),
    .pat_i  (cur_pat),
    .eq_o   (match)
  );

  scan_ctrl #(.PAT_W(PAT_W), .N_STEPS(N_STEPS), .LAST_W(LAST_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .last_i  (last_q),
    .pat_i   (pat_i),
    .match_i (match),
    .idx_o   (rd_idx),
    .pat_o   (cur_pat),
    .busy_o  (busy),
    .done_o  (done_o),
    .hit_o   (hit_o),
    .step_o  (step_o),
    .eno_o   (eno_o),
    .err_o   (err_o)
  );
endmodule

// File: rtl/pattern_scan_cmp_chk.sv
module pattern_scan_cmp_chk #(
  parameter int N_STEPS = 16,
  parameter int LAST_W  = 8,
  localparam int STEP_W = $clog2(N_STEPS + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              en_i,
  input logic              busy_i,
  input logic [LAST_W-1:0] last_q_i,
  input logic              done_o,
  input logic              hit_o,
  input logic [STEP_W-1:0] step_o,
  input logic              eno_o,
  input logic [15:0]       err_o
);
  a_r6_range_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && req_i && en_i && last_q_i > LAST_W'(N_STEPS - 1))
    |=> (done_o && !eno_o && !hit_o && err_o == 16'h000E));

  a_r6_fault_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !eno_o) |-> (err_o == 16'h000E && !hit_o && step_o == '0));

  a_r7_ok_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && eno_o) |-> (err_o == 16'h0000));

  a_r4_hit_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && hit_o) |-> (step_o <= STEP_W'(N_STEPS - 1)));

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(hit_o) && $stable(step_o) && $stable(eno_o) && $stable(err_o)));

  a_r10_scan_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && eno_o) |=> !done_o);

  a_r9_no_done_midscan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> !done_o);
endmodule

bind pattern_scan_cmp pattern_scan_cmp_chk #(.N_STEPS(N_STEPS), .LAST_W(LAST_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .en_i     (en_i),
  .busy_i   (busy),
  .last_q_i (last_q),
  .done_o   (done_o),
  .hit_o    (hit_o),
  .step_o   (step_o),
  .eno_o    (eno_o),
  .err_o    (err_o)
);

// File: tb/pattern_scan_cmp_test.sv
`timescale 1ns/1ps
module pattern_scan_cmp_test;
  localparam int PAT_W = 16, N_STEPS = 16, LAST_W = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 0, last_we_i = 0, req_i = 0, en_i = 0;
  logic [3:0]  wr_step_i = '0;
  logic [15:0] wr_mask_i = '0, pat_i = '0;
  logic [7:0]  last_i = '0;
  logic done_o, hit_o, eno_o;
  logic [4:0]  step_o;
  logic [15:0] err_o;

  int checks = 0, fails = 0;
  logic [15:0] mdl_mask [N_STEPS];
  int mdl_last = 0;
  int got_lat;

  always #2.5 clk_i = ~clk_i;

  pattern_scan_cmp #(.PAT_W(PAT_W), .N_STEPS(N_STEPS), .LAST_W(LAST_W)) uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int first_hit(input logic [15:0] p, input int last);
    for (int s = 0; s <= last; s++)
      if (mdl_mask[s] == p) return s;
    return -1;
  endfunction

  task automatic put_mask(input int s, input logic [15:0] m);
    @(negedge clk_i);
    wr_en_i = 1; wr_step_i = 4'(s); wr_mask_i = m;
    @(negedge clk_i);
    wr_en_i = 0;
    mdl_mask[s] = m;
  endtask

  task automatic put_last(input int v);
    @(negedge clk_i);
    last_we_i = 1; last_i = 8'(v);
    @(negedge clk_i);
    last_we_i = 0;
    mdl_last = v;
  endtask

  // issue request, wait for done, return latency (-1 if none)
  task automatic issue(input logic [15:0] p, output int lat);
    @(negedge clk_i);
    req_i = 1; en_i = 1; pat_i = p;
    lat = -1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk_i);
      if (c == 0) begin req_i = 0; pat_i = ~p; end // R12 pattern change after capture
      if (done_o) begin lat = c; break; end
    end
  endtask

  task automatic run_and_check(input logic [15:0] p, input string tag);
    int s, exp_lat;
    issue(p, got_lat);
    if (mdl_last > N_STEPS - 1) begin
      chk(got_lat == 0, {tag, " R6 latency"}, got_lat, 0);
      chk(eno_o == 0 && err_o == 16'h000E && hit_o == 0 && step_o == 0,
          {tag, " R6 fault fields"}, int'(err_o), 14);
    end else begin
      s = first_hit(p, mdl_last);
      exp_lat = (s >= 0) ? s + 1 : mdl_last + 1;
      chk(got_lat == exp_lat, {tag, " R3 latency"}, got_lat, exp_lat);
      if (s >= 0) chk(hit_o == 1 && int'(step_o) == s, {tag, " R4 hit step"}, int'(step_o), s);
      else        chk(hit_o == 0 && int'(step_o) == mdl_last + 1, {tag, " R5 miss step"},
                      int'(step_o), mdl_last + 1);
      chk(eno_o == 1 && err_o == 0, {tag, " R7 ok status"}, int'(err_o), 0);
    end
    @(negedge clk_i);
    chk(done_o == 0, {tag, " R10 single pulse"}, int'(done_o), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [15:0] pool [4];
    int old_step;
    void'($urandom(32'h5A17));
    for (int s = 0; s < N_STEPS; s++) mdl_mask[s] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk(done_o == 0 && hit_o == 0 && step_o == 0 && eno_o == 0 && err_o == 0,
        "R1 reset outputs", int'(step_o), 0);
    run_and_check(16'h0000, "R1 zero masks");
    put_last(15);
    run_and_check(16'h0001, "R11 last load miss");

    // R2 / R3 directed: one-bit neighbour, duplicate rows
    for (int s = 0; s < N_STEPS; s++) put_mask(s, 16'h1000 + 16'(s));
    put_mask(3, 16'hA5C3 ^ 16'h0400);
    put_mask(5, 16'hA5C3);
    put_mask(9, 16'hA5C3);
    run_and_check(16'hA5C3, "R2 R3 lowest wins");
    put_mask(15, 16'h7E7E);
    run_and_check(16'h7E7E, "R4 top step");
    put_last(14);
    run_and_check(16'h7E7E, "R5 beyond last");
    put_last(16);
    run_and_check(16'hA5C3, "R6 last 16");
    put_last(255);
    run_and_check(16'hA5C3, "R6 last 255");

    // R8 enable low
    put_last(15);
    old_step = int'(step_o);
    @(negedge clk_i);
    req_i = 1; en_i = 0; pat_i = 16'h1000;
    @(negedge clk_i);
    req_i = 0;
    begin
      bit seen = 0;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk_i);
        if (done_o) seen = 1;
      end
      chk(!seen && int'(step_o) == old_step && eno_o == 0, "R8 enable low ignored",
          int'(seen), 0);
    end

    // R9 / R12 request during scan ignored
    put_mask(0, 16'hBEEF);
    mdl_mask[5] = 16'hA5C3;
    @(negedge clk_i);
    req_i = 1; en_i = 1; pat_i = 16'hDEAD;
    got_lat = -1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk_i);
      req_i = (c >= 1 && c <= 4);
      pat_i = 16'hBEEF;
      if (done_o) begin got_lat = c; break; end
    end
    req_i = 0;
    chk(got_lat == 16, "R9 R12 scan not restarted", got_lat, 16);
    chk(hit_o == 0 && step_o == 16, "R12 captured pattern used", int'(step_o), 16);
    begin
      bit seen = 0;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk_i);
        if (done_o) seen = 1;
      end
      chk(!seen, "R9 no second done", int'(seen), 0);
    end

    // random mix
    for (int it = 0; it < 60; it++) begin
      for (int k = 0; k < 4; k++) pool[k] = 16'($urandom);
      for (int s = 0; s < N_STEPS; s++)
        put_mask(s, ($urandom % 3 == 0) ? pool[$urandom % 4] : 16'($urandom));
      put_last(($urandom % 5 == 0) ? 16 + int'($urandom % 240) : int'($urandom % 16));
      for (int r = 0; r < 3; r++)
        run_and_check(($urandom % 4 == 0) ? 16'($urandom) : pool[$urandom % 4], "rand");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule